// File: doc/BRIEF.md
# Bus-Kicked Watchdog Reset Generator

This block produces the system reset of a small controller subsystem. The reset has three causes: chip power-up, a digital low-supply flag, and a watchdog that runs out. A dedicated strobe does not feed the watchdog. It restarts whenever a START condition appears on the two-wire serial bus that the host already drives, meaning SDA falls while SCL is high. The block samples both bus lines on the system clock.

A two-bit select sets one of three timeout windows or turns the watchdog off. Every delay is a parameter: a count of ticks, where each tick is `PRESCALE` system clocks. The block has two outputs:
- a reset whose polarity is fixed at build time;
- a bus-inhibit flag for the serial slave. While this flag is high, the slave ignores the bus, drops any transfer in progress and starts no new nonvolatile write. A write already running may finish.

Top module: `bus_wdt_rst_gen`

## Requirements
- R1: A kick is SDA going 1 to 0 while SCL is 1, seen after a two-flop synchronizer and one edge-detect flop. A kick restarts the watchdog window, and the window expires `T*PRESCALE` cycles after the kick is registered.
- R2: No other bus activity restarts the watchdog. This covers SCL toggling, SDA changing while SCL is 0, and a STOP (SDA rising while SCL is 1).
- R3: `wdt_sel_i` encoding:
  - 00 gives `T_LONG` ticks (nominally 1.4 s).
  - 01 gives `T_MID` ticks (nominally 600 ms).
  - 10 gives `T_SHORT` ticks (nominally 200 ms).
  - 11 disables the watchdog and is the default setting. While it is 11, the watchdog never causes a reset.
- R4: When the watchdog expires, reset is asserted for exactly `T_WDT_HOLD*PRESCALE` cycles (nominally 250 ms).
- R5: After `rst_ni` is released with the low-supply flag clear, reset stays active for `T_STABLE*PRESCALE` cycles (nominally 200 ms).
- R6: While the synchronized `low_supply_i` is 1, reset stays active. After the flag clears, reset stays active for a further `T_STABLE*PRESCALE` cycles.
- R7: `bus_inhibit_o` is 1 exactly while reset is active. While it is 1, bus edges are not treated as kicks.
- R8: With `ACTIVE_LOW=1`, `sys_rst_o` is 0 while reset is active. With `ACTIVE_LOW=0`, `sys_rst_o` is 1 while reset is active.
- R9: When reset is released, the watchdog restarts from zero. The first window after release is a full `T*PRESCALE` cycles.
- R10: A change of `wdt_sel_i` while the watchdog runs reloads the counter. The new window is counted from the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| low_supply_i | input | 1 | Low-supply flag, asynchronous, high while the supply is under its trip point |
| scl_i | input | 1 | Serial bus clock line, asynchronous |
| sda_i | input | 1 | Serial bus data line, asynchronous |
| wdt_sel_i | input | 2 | Timeout select: 00 long, 01 mid, 10 short, 11 off |
| sys_rst_o | output | 1 | System reset, polarity set by `ACTIVE_LOW` |
| bus_inhibit_o | output | 1 | High while reset is active. The serial slave ignores the bus while it is high |

## Verification
Latencies are counted in rising edges after the edge at which a stimulus first becomes visible:
- A kick takes effect at the third edge. Reset therefore rises exactly `T*PRESCALE+3` edges after the SDA fall.
- A select change reloads at the first edge, so reset rises `T*PRESCALE+1` edges later.
- Low-supply entry shows at the third edge. Release comes `T_STABLE*PRESCALE+2` edges after the flag clears.
- Power-up release comes after `T_STABLE*PRESCALE` edges.

The bench drives on the falling clock and samples on the falling clock after the edge counts above. At each edge that bounds a result it samples one cycle before and one cycle after. Random kick trains use gaps that end well inside the window, so the only exact checks fall on the final expiry and on the release that follows it.

// File: rtl/brg_pkg.sv
`timescale 1ns/1ps
package brg_pkg;
  typedef enum logic [1:0] {
    WDT_LONG  = 2'b00,
    WDT_MID   = 2'b01,
    WDT_SHORT = 2'b10,
    WDT_OFF   = 2'b11
  } wdt_sel_e;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } rst_state_e;
endpackage

// File: rtl/brg_sync.sv
`timescale 1ns/1ps
module brg_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/brg_tick_gen.sv
`timescale 1ns/1ps
module brg_tick_gen #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick_o = ~clr_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pcnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               pcnt_q <= '0;
        else if (clr_i)            pcnt_q <= '0;
        else if (pcnt_q == LAST)   pcnt_q <= '0;
        else                       pcnt_q <= pcnt_q + 1'b1;
      end

      assign tick_o = ~clr_i & (pcnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/brg_start_det.sv
`timescale 1ns/1ps
module brg_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic block_i,
  output logic kick_o
);
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s_i;
      sda_d_q <= sda_s_i;
    end
  end

  // SCL high on both samples so a simultaneous SCL fall does not count
  assign kick_o = ~block_i & scl_s_i & scl_d_q & sda_d_q & ~sda_s_i;
endmodule

// File: rtl/brg_wdt.sv
`timescale 1ns/1ps
module brg_wdt
  import brg_pkg::*;
#(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned T_LONG   = 28,
  parameter int unsigned T_MID    = 12,
  parameter int unsigned T_SHORT  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       kick_i,
  input  logic       hold_i,
  output logic       sel_off_o,
  output logic       expire_o
);
  localparam int unsigned CW = $clog2(T_LONG + 1);

  logic [1:0]    sel_q;
  logic [CW-1:0] cnt_q, lim;
  logic          sel_chg, clr, tick;
  wdt_sel_e      sel;

  assign sel       = wdt_sel_e'(sel_i);
  assign sel_off_o = (sel == WDT_OFF);
  assign sel_chg   = (sel_i != sel_q);
  assign clr       = hold_i | kick_i | sel_chg | sel_off_o;

  always_comb begin
    unique case (sel)
      WDT_LONG:  lim = CW'(T_LONG  - 1);
      WDT_MID:   lim = CW'(T_MID   - 1);
      WDT_SHORT: lim = CW'(T_SHORT - 1);
      default:   lim = '0;
    endcase
  end

  brg_tick_gen #(.PRESCALE(PRESCALE)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= WDT_OFF;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (clr)       cnt_q <= '0;
      else if (tick) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
  end

  assign expire_o = tick & (cnt_q == lim);
endmodule

// File: rtl/brg_rst_ctrl.sv
`timescale 1ns/1ps
module brg_rst_ctrl
  import brg_pkg::*;
#(
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned T_STABLE   = 4,
  parameter int unsigned T_WDT_HOLD = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  input  logic expire_i,
  output logic active_o
);
  localparam int unsigned TMAX = (T_STABLE > T_WDT_HOLD) ? T_STABLE : T_WDT_HOLD;
  localparam int unsigned CW   = $clog2(TMAX + 1);

  rst_state_e    state_q;
  logic [CW-1:0] cnt_q, lim;
  logic          from_wdt_q, tick;

  assign lim = from_wdt_q ? CW'(T_WDT_HOLD - 1) : CW'(T_STABLE - 1);

  brg_tick_gen #(.PRESCALE(PRESCALE)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (low_i | (state_q == ST_RUN)),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HOLD;
      cnt_q      <= '0;
      from_wdt_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (low_i) begin
            state_q    <= ST_HOLD;
            cnt_q      <= '0;
            from_wdt_q <= 1'b0;
          end else if (expire_i) begin
            state_q    <= ST_HOLD;
            cnt_q      <= '0;
            from_wdt_q <= 1'b1;
          end
        end
        default: begin
          if (low_i) begin
            cnt_q      <= '0;
            from_wdt_q <= 1'b0;
          end else if (tick) begin
            if (cnt_q == lim) begin
              state_q <= ST_RUN;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign active_o = (state_q == ST_HOLD);
endmodule

// File: rtl/bus_wdt_rst_gen.sv
`timescale 1ns/1ps
module bus_wdt_rst_gen #(
  parameter bit          ACTIVE_LOW = 1'b1,
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned T_LONG     = 28,
  parameter int unsigned T_MID      = 12,
  parameter int unsigned T_SHORT    = 4,
  parameter int unsigned T_WDT_HOLD = 5,
  parameter int unsigned T_STABLE   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       low_supply_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] wdt_sel_i,
  output logic       sys_rst_o,
  output logic       bus_inhibit_o
);
  logic scl_s, sda_s, low_s;
  logic kick, wdt_expire, rst_active, sel_off;

  brg_sync #(.W(3), .RST_VAL(3'b110)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i, low_supply_i}),
    .q_o    ({scl_s, sda_s, low_s})
  );

  brg_start_det i_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_s_i (scl_s),
    .sda_s_i (sda_s),
    .block_i (rst_active),
    .kick_o  (kick)
  );

  brg_wdt #(
    .PRESCALE (PRESCALE),
    .T_LONG   (T_LONG),
    .T_MID    (T_MID),
    .T_SHORT  (T_SHORT)
  ) i_wdt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (wdt_sel_i),
    .kick_i    (kick),
    .hold_i    (rst_active),
    .sel_off_o (sel_off),
    .expire_o  (wdt_expire)
  );

  brg_rst_ctrl #(
    .PRESCALE   (PRESCALE),
    .T_STABLE   (T_STABLE),
    .T_WDT_HOLD (T_WDT_HOLD)
  ) i_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .low_i    (low_s),
    .expire_i (wdt_expire),
    .active_o (rst_active)
  );

  assign sys_rst_o     = ACTIVE_LOW ? ~rst_active : rst_active;
  assign bus_inhibit_o = rst_active;
endmodule

// File: rtl/bus_wdt_rst_gen_chk.sv
`timescale 1ns/1ps
module bus_wdt_rst_gen_chk #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic kick,
  input logic wdt_expire,
  input logic rst_active,
  input logic sel_off,
  input logic low_s,
  input logic sys_rst_o,
  input logic bus_inhibit_o
);
  AST_KICK_BLOCKS_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> !wdt_expire); // R1
  AST_OFF_NEVER_EXPIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_expire |-> !sel_off && !rst_active); // R3
  AST_EXPIRE_ASSERTS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_expire |=> rst_active); // R4
  AST_LOW_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_s |=> rst_active); // R6
  AST_RELEASE_ONLY_WHEN_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_active) |-> !$past(low_s)); // R6
  AST_NO_KICK_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active |-> !kick); // R7
  AST_POLARITY_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_inhibit_o == (ACTIVE_LOW ? !sys_rst_o : sys_rst_o)); // R8
endmodule

bind bus_wdt_rst_gen bus_wdt_rst_gen_chk #(.ACTIVE_LOW(ACTIVE_LOW)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .kick          (kick),
  .wdt_expire    (wdt_expire),
  .rst_active    (rst_active),
  .sel_off       (sel_off),
  .low_s         (low_s),
  .sys_rst_o     (sys_rst_o),
  .bus_inhibit_o (bus_inhibit_o)
);

// File: tb/test_bus_wdt_rst_gen.sv
`timescale 1ns/1ps
module test_bus_wdt_rst_gen;
  localparam int unsigned P  = 4;
  localparam int unsigned TL = 28;
  localparam int unsigned TM = 12;
  localparam int unsigned TS = 4;
  localparam int unsigned TH = 5;
  localparam int unsigned TB = 4;
  localparam int HP = TH * P;
  localparam int SP = TB * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic low = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic [1:0] sel = 2'b11;
  logic rst_lo, inh_lo, rst_hi, inh_hi;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  bus_wdt_rst_gen #(.ACTIVE_LOW(1'b1), .PRESCALE(P), .T_LONG(TL), .T_MID(TM),
    .T_SHORT(TS), .T_WDT_HOLD(TH), .T_STABLE(TB)) i_bus_wdt_rst_gen (
    .clk_i(clk), .rst_ni(rst_n), .low_supply_i(low), .scl_i(scl), .sda_i(sda),
    .wdt_sel_i(sel), .sys_rst_o(rst_lo), .bus_inhibit_o(inh_lo));

  bus_wdt_rst_gen #(.ACTIVE_LOW(1'b0), .PRESCALE(P), .T_LONG(TL), .T_MID(TM),
    .T_SHORT(TS), .T_WDT_HOLD(TH), .T_STABLE(TB)) i_bus_wdt_rst_gen_pos (
    .clk_i(clk), .rst_ni(rst_n), .low_supply_i(low), .scl_i(scl), .sda_i(sda),
    .wdt_sel_i(sel), .sys_rst_o(rst_hi), .bus_inhibit_o(inh_hi));

  function automatic int win(input logic [1:0] s);
    case (s)
      2'b00:   return TL * P;
      2'b01:   return TM * P;
      2'b10:   return TS * P;
      default: return 0;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input logic exp_act, input string tag);
    n_chk++;
    if (inh_lo !== exp_act || rst_lo !== !exp_act || inh_hi !== exp_act || rst_hi !== exp_act) begin
      n_err++;
      $display("FAIL %s: inhibit=%b rst_n=%b rst_p=%b expected inhibit=%b rst_n=%b rst_p=%b",
               tag, inh_lo, rst_lo, rst_hi, exp_act, !exp_act, exp_act);
    end
  endtask

  // 4 steps, starts and ends idle; the SDA fall is at the first drive
  task automatic kick();
    sda = 1'b0; step();
    scl = 1'b0; step();
    sda = 1'b1; step();
    scl = 1'b1; step();
  endtask

  task automatic stop_cond();
    scl = 1'b0; step();
    sda = 1'b0; step();
    scl = 1'b1; step();
    sda = 1'b1; step();
  endtask

  // g noise steps then 3 restore steps; SDA moves only while SCL is low
  task automatic noise(input int g);
    for (int i = 0; i < g; i++) begin
      case (i % 4)
        0: scl = 1'b0;
        1: sda = 1'($urandom_range(0, 1));
        2: scl = 1'b1;
        default: ;
      endcase
      step();
    end
    scl = 1'b0; step();
    sda = 1'b1; step();
    scl = 1'b1; step();
  endtask

  initial begin
    void'($urandom(32'd20250611));
    @(negedge clk);
    chk(1'b1, "R8 reset during rst_ni");
    step();
    rst_n = 1'b1;
    steps(SP - 1);
    chk(1'b1, "R5 power-up hold last cycle");
    step();
    chk(1'b0, "R5 power-up release");

    steps(3 * TL * P);
    chk(1'b0, "R3 select 11 disables watchdog");

    // R2: only non-START activity inside a short window
    sel = 2'b10;
    stop_cond();
    noise(win(2'b10) - 7);
    chk(1'b0, "R2 no expiry before window end");
    step();
    chk(1'b1, "R2 expiry despite SCL toggles and STOP");
    steps(HP - 1);
    chk(1'b1, "R4 watchdog hold last cycle");
    step();
    chk(1'b0, "R4 watchdog hold release");
    steps(win(2'b10) - 1);
    chk(1'b0, "R9 full window after release");
    step();
    chk(1'b1, "R9 expiry at full window");
    steps(HP);
    chk(1'b0, "R4 second hold release");

    // R1: exact kick latency, mid window
    sel = 2'b01;
    kick();
    steps(win(2'b01) + 2 - 4);
    chk(1'b0, "R1 kick window not yet expired");
    step();
    chk(1'b1, "R1 kick window expired");
    steps(HP);
    chk(1'b0, "R4 hold after mid window");

    // R10: select change mid-run reloads
    sel = 2'b10;
    kick();
    steps(6);
    sel = 2'b00;
    steps(win(2'b00));
    chk(1'b0, "R10 reload keeps reset off past old window");
    step();
    chk(1'b1, "R10 expiry of reloaded window");
    steps(HP);
    chk(1'b0, "R10 release after reload expiry");

    // R6: low supply
    sel = 2'b11;
    low = 1'b1;
    steps(2);
    chk(1'b0, "R6 low flag still in synchronizer");
    step();
    chk(1'b1, "R6 low flag asserts reset");
    for (int i = 0; i < 4; i++) begin
      kick();
      noise(2);
    end
    chk(1'b1, "R7 bus activity during low supply keeps reset");
    low = 1'b0;
    steps(SP + 1);
    chk(1'b1, "R6 stable hold last cycle");
    step();
    chk(1'b0, "R6 stable hold release");

    // random kick trains
    for (int it = 0; it < 12; it++) begin
      logic [1:0] s;
      int nk, lw;
      s  = 2'($urandom_range(0, 2));
      lw = win(s);
      sel = s;
      kick();
      nk = $urandom_range(1, 3);
      for (int k = 0; k < nk; k++) begin
        noise($urandom_range(0, lw - 12));
        chk(1'b0, "R1 random kicks keep reset off");
        kick();
      end
      steps(lw + 2 - 4);
      chk(1'b0, "R3 random window before expiry");
      step();
      chk(1'b1, "R3 random window expiry");
      steps(HP);
      chk(1'b0, "R4 random hold release");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule